// File: doc/BRIEF.md
# Unlock-Gated Expiry-Counting Watchdog

The block counts expiry pulses from one of up to sixteen external timer channels. When the number of pulses since the last start reaches a programmed period, the watchdog fires. It then raises whichever of four actions are enabled: an interrupt request, a fast-interrupt request, a system reset request and a power-controller reset request. The timers that produce the pulses and the reset generator that consumes the reset requests are outside the block.

Software reaches the block through a simple single-cycle write port and a combinational read port. The setup register and the command register are protected: a write to either takes effect only if the write before it on the port placed the 16-bit key 0xC45A into the key register. Each key arms exactly one protected write. A command with the start bit re-arms a running watchdog: the count returns to zero and any pending interrupt requests are dropped. A command with the stop bit halts it.

Top module: `wdt_guard`

## Requirements
- R1: After reset all four action outputs are low, and reads of the setup register (address 1) and status register (address 3) return 0. Reads of address 0 and address 2 always return 0.
- R2: A write to setup (address 1) or command (address 2) takes effect only when the most recent write on the port was the value 0xC45A to the key register (address 0). Otherwise it is ignored.
- R3: The key is consumed by the next write to address 1 or address 2, whether or not that write had an effect. A key write with any value other than 0xC45A disarms the key.
- R4: Setup bits [3:0] select the timer channel. While running, pulses on any other channel leave the count unchanged.
- R5: Setup bits [11:4] give the period P. The watchdog fires on the P-th selected pulse after start, and the count then returns to 0. A period of 0 acts as 1. After firing, further pulses are ignored until the next start.
- R6: Setup bits 12, 13, 14 and 15 enable irq_o, fiq_o, sysrst_o and pmcrst_o respectively. On firing, only the enabled outputs assert, one cycle after the edge that sampled the final pulse.
- R7: A command with bit 0 set and bit 1 clear starts the watchdog, or restarts it if it is running. This clears the count, the fired flag, irq_o and fiq_o.
- R8: A command with bit 1 set stops the watchdog, even if bit 0 is also set. This clears the count, the running flag, the fired flag, irq_o and fiq_o. While stopped, pulses change nothing and no output asserts.
- R9: Once asserted, sysrst_o and pmcrst_o stay high through stop and restart commands until rst_n is asserted.
- R10: The status register reads the count in bits [7:0], running in bit 8 and fired in bit 9, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | Write address: 0 key, 1 setup, 2 command |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address: 1 setup, 3 status |
| rd_data | output | 16 | Combinational read data |
| tick_i | input | NUM_SRC | One-cycle expiry pulses from the timer channels |
| irq_o | output | 1 | Interrupt request |
| fiq_o | output | 1 | Fast-interrupt request |
| sysrst_o | output | 1 | System reset request, sticky |
| pmcrst_o | output | 1 | Power-controller reset request, sticky |

## Verification
Protected writes are tried in several ways: without a key, after a key, a second time after one key, and after a key with the wrong value. Together these show that the gate accepts exactly one write per correct key. Pulses on a channel that is not selected, followed by pulses on the selected channel, show that the channel select works and that the count is exact. Periods of 3, 2, 1 and 0 are used: 3 and 2 test the count, and 0 tests the rule that a period of 0 acts as 1. Each run enables a different action, so a wrong bit-to-output mapping shows up. Restart, stop, stop combined with start, and a final reset show which outputs are cleared by a command and which only a reset clears.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 2;
  localparam int SEL_W   = 4;
  localparam int PER_W   = 8;
  localparam int N_ACT   = 4;
  localparam int MAX_SRC = 1 << SEL_W;

  localparam logic [ADDR_W-1:0] A_KEY  = 2'd0;
  localparam logic [ADDR_W-1:0] A_SET  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CMD  = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

  typedef struct packed {
    logic [N_ACT-1:0] act_en;  // [15:12]: pmcrst, sysrst, fiq, irq
    logic [PER_W-1:0] period;  // [11:4]
    logic [SEL_W-1:0] sel;     // [3:0]
  } setup_t;
endpackage

// File: rtl/wdt_keygate.sv
module wdt_keygate
  import wdt_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY = 16'hC45A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              set_we,
  output logic              cmd_we
);
  logic armed_q, armed_d;
  logic key_wr, prot_wr;

  assign key_wr  = wr_en && (wr_addr == A_KEY);
  assign prot_wr = wr_en && ((wr_addr == A_SET) || (wr_addr == A_CMD));

  always_comb begin
    armed_d = armed_q;
    if (key_wr)       armed_d = (wr_data == KEY);
    else if (prot_wr) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign set_we = prot_wr && armed_q && (wr_addr == A_SET);
  assign cmd_we = prot_wr && armed_q && (wr_addr == A_CMD);

  // R3
  key_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we || cmd_we) |=> !armed_q);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_SRC-1:0] tick_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             fire_o,
  output logic             run_o,
  output logic             fired_o,
  output logic [PER_W-1:0] count_o
);
  logic [MAX_SRC-1:0] tick_ext;
  logic               tick_sel;
  logic [PER_W-1:0]   per_eff;
  logic               hit;
  logic               run_q, run_d, fired_q, fired_d;
  logic [PER_W-1:0]   count_q, count_d;

  for (genvar k = 0; k < MAX_SRC; k++) begin : g_pad
    if (k < NUM_SRC) begin : g_src
      assign tick_ext[k] = tick_i[k];
    end else begin : g_none
      assign tick_ext[k] = 1'b0;
    end
  end

  assign tick_sel = tick_ext[sel_i];
  assign per_eff  = (period_i == '0) ? PER_W'(1) : period_i;
  assign hit      = ({1'b0, count_q} + 1'b1) >= {1'b0, per_eff};
  assign fire_o   = run_q && !fired_q && tick_sel && hit && !start_i && !stop_i;

  always_comb begin
    run_d   = run_q;
    fired_d = fired_q;
    count_d = count_q;
    if (stop_i) begin
      run_d = 1'b0; fired_d = 1'b0; count_d = '0;
    end else if (start_i) begin
      run_d = 1'b1; fired_d = 1'b0; count_d = '0;
    end else if (run_q && !fired_q && tick_sel) begin
      if (hit) begin
        fired_d = 1'b1; count_d = '0;
      end else begin
        count_d = count_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; fired_q <= 1'b0; count_q <= '0;
    end else begin
      run_q <= run_d; fired_q <= fired_d; count_q <= count_d;
    end
  end

  assign run_o   = run_q;
  assign fired_o = fired_q;
  assign count_o = count_q;

  // R5
  fire_resets_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (fired_q && count_q == '0));
  // R8
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!run_q && !fired_q && count_q == '0));
  // R8
  idle_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_i) |=> (count_q == '0 && !fired_q));
endmodule

// File: rtl/wdt_actions.sv
module wdt_actions
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ACT-1:0] en_i,
  input  logic             fire_i,
  input  logic             clr_i,
  output logic [N_ACT-1:0] act_o
);
  logic [N_ACT-1:0] act_q, act_d;

  for (genvar i = 0; i < N_ACT; i++) begin : g_act
    if (i < 2) begin : g_intr
      always_comb begin
        act_d[i] = act_q[i];
        if (clr_i)                   act_d[i] = 1'b0;
        else if (fire_i && en_i[i])  act_d[i] = 1'b1;
      end
    end else begin : g_rst
      always_comb begin
        act_d[i] = act_q[i] || (fire_i && en_i[i]);
      end
      // R9
      rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_q[i] |=> act_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  assign act_o = act_q;

  // R6
  act_rise_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) && ((act_q & ~$past(act_q)) != '0) |-> $past(fire_i));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int                NUM_SRC = 16,
  parameter logic [DATA_W-1:0] KEY     = 16'hC45A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [NUM_SRC-1:0] tick_i,
  output logic               irq_o,
  output logic               fiq_o,
  output logic               sysrst_o,
  output logic               pmcrst_o
);
  logic             set_we, cmd_we, start, stop;
  setup_t           setup_q, setup_d;
  logic             fire, run, fired;
  logic [PER_W-1:0] count;
  logic [N_ACT-1:0] act;

  wdt_keygate #(.KEY(KEY)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .set_we(set_we), .cmd_we(cmd_we)
  );

  always_comb begin
    setup_d = setup_q;
    if (set_we) setup_d = setup_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) setup_q <= '0;
    else        setup_q <= setup_d;
  end

  assign stop  = cmd_we && wr_data[1];
  assign start = cmd_we && wr_data[0] && !wr_data[1];

  wdt_counter #(.NUM_SRC(NUM_SRC)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sel_i(setup_q.sel),
    .period_i(setup_q.period), .start_i(start), .stop_i(stop),
    .fire_o(fire), .run_o(run), .fired_o(fired), .count_o(count)
  );

  wdt_actions u_act (
    .clk(clk), .rst_n(rst_n), .en_i(setup_q.act_en), .fire_i(fire),
    .clr_i(start || stop), .act_o(act)
  );

  assign irq_o    = act[0];
  assign fiq_o    = act[1];
  assign sysrst_o = act[2];
  assign pmcrst_o = act[3];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_SET:   rd_data = setup_q;
      A_STAT:  rd_data = {6'b0, fired, run, count};
      default: rd_data = '0;
    endcase
  end

  // R7
  start_clears_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!irq_o && !fiq_o && run && !fired));
  // R2
  setup_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_we |=> (setup_q == $past(setup_q)));
endmodule

// File: tb/wdt_guard_bench.sv
module wdt_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [15:0] tick_i = '0;
  logic        irq_o, fiq_o, sysrst_o, pmcrst_o;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  wdt_guard u_wdt_guard (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick_i(tick_i), .irq_o(irq_o), .fiq_o(fiq_o),
    .sysrst_o(sysrst_o), .pmcrst_o(pmcrst_o)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic kwr(logic [1:0] a, logic [15:0] d);
    wr(2'd0, 16'hC45A);
    wr(a, d);
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic pulse(int src, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_i = 16'(1) << src;
      @(negedge clk);
      tick_i = '0;
    end
  endtask

  function automatic logic [15:0] outs();
    return {12'b0, pmcrst_o, sysrst_o, fiq_o, irq_o};
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd1, v); check("R1 setup", v, 16'h0);
    rd(2'd3, v); check("R1 status", v, 16'h0);
    rd(2'd2, v); check("R1 cmd read", v, 16'h0);
    check("R1 outputs", outs(), 16'h0);
  endtask

  task automatic t_lock();
    logic [15:0] v;
    wr(2'd1, 16'h1234);
    rd(2'd1, v); check("R2 unkeyed setup", v, 16'h0);
    kwr(2'd1, 16'h1034);
    rd(2'd1, v); check("R2 keyed setup", v, 16'h1034);
    wr(2'd1, 16'h2222);
    rd(2'd1, v); check("R3 key consumed", v, 16'h1034);
    wr(2'd0, 16'hC45B);
    wr(2'd1, 16'h4444);
    rd(2'd1, v); check("R3 wrong key", v, 16'h1034);
    wr(2'd2, 16'h0001);
    rd(2'd3, v); check("R2 unkeyed start", v, 16'h0);
  endtask

  task automatic t_count();
    logic [15:0] v;
    kwr(2'd1, 16'h1033);          // irq only, period 3, channel 3
    kwr(2'd2, 16'h0001);
    rd(2'd3, v); check("R10 running", v, 16'h0100);
    pulse(5, 2);
    rd(2'd3, v); check("R4 other channel", v, 16'h0100);
    pulse(3, 2);
    rd(2'd3, v); check("R5 count 2", v, 16'h0102);
    check("R5 no early fire", outs(), 16'h0);
    pulse(3, 1);
    rd(2'd3, v); check("R10 fired", v, 16'h0300);
    check("R6 irq only", outs(), 16'h0001);
    pulse(3, 2);
    rd(2'd3, v); check("R5 ignored after fire", v, 16'h0300);
  endtask

  task automatic t_rearm();
    logic [15:0] v;
    kwr(2'd2, 16'h0001);
    check("R7 irq cleared", outs(), 16'h0);
    rd(2'd3, v); check("R7 restart status", v, 16'h0100);
    pulse(3, 1);
    rd(2'd3, v); check("R7 count 1", v, 16'h0101);
    kwr(2'd2, 16'h0001);
    rd(2'd3, v); check("R7 count cleared", v, 16'h0100);
  endtask

  task automatic t_stop();
    logic [15:0] v;
    kwr(2'd2, 16'h0003);
    rd(2'd3, v); check("R8 stop wins", v, 16'h0);
    pulse(3, 5);
    rd(2'd3, v); check("R8 pulses ignored", v, 16'h0);
    check("R8 outputs low", outs(), 16'h0);
    kwr(2'd1, 16'h2010);          // fiq, period 1, channel 0
    kwr(2'd2, 16'h0001);
    pulse(0, 1);
    check("R6 fiq only", outs(), 16'h0002);
    kwr(2'd2, 16'h0002);
    check("R8 stop clears fiq", outs(), 16'h0);
  endtask

  task automatic t_resets();
    logic [15:0] v;
    kwr(2'd1, 16'h4002);          // sysrst, period 0, channel 2
    kwr(2'd2, 16'h0001);
    pulse(2, 1);
    check("R5 period0 fires at 1", outs(), 16'h0004);
    kwr(2'd2, 16'h0002);
    check("R9 sysrst after stop", outs(), 16'h0004);
    kwr(2'd1, 16'h8022);          // pmcrst, period 2, channel 2
    kwr(2'd2, 16'h0001);
    check("R9 sysrst after start", outs(), 16'h0004);
    pulse(2, 1);
    check("R6 pmc not yet", outs(), 16'h0004);
    pulse(2, 1);
    check("R6 pmcrst", outs(), 16'h000C);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R9 cleared by reset", outs(), 16'h0);
    rd(2'd1, v); check("R1 setup after reset", v, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lock();
    t_count();
    t_rearm();
    t_stop();
    t_resets();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule